// File: doc/BRIEF.md
# Selectable Zero-Substitution Bipolar Line Encoder

This block turns a single-rail NRZ bit stream into a bipolar dual-rail symbol stream made of a positive-pulse rail and a negative-pulse rail. It takes one bit for each cycle in which the clock enable is high. A one becomes a mark, and successive marks alternate in polarity. Long runs of zeros are replaced by short groups that carry a deliberate polarity violation, which gives the far-end clock recovery enough transitions to lock. The `mode` input selects the group length. With `mode` low, runs of three zeros are replaced, which suits DS3 and STS-1 lines. With `mode` high, runs of four zeros are replaced, which suits E3 lines. When `sub_en` is low, the block emits plain alternate-mark inversion.

Two substitution groups exist in each mode: one of all zeros ending in a violation, and one that starts with a normal alternating pulse and ends in a violation. The block picks between them so that the number of pulses between any two violations is odd. Bits pass through a fixed four-slot symbol pipeline. Polarity is resolved as each bit enters the pipeline, and the first slot of a completed zero run is rewritten in place. The latency is therefore the same in both modes.

The polarity and parity tracker is a four-state machine:
- `TRK_NEG_EVEN`: the last pulse was negative and an even number of pulses has been sent since the last violation.
- `TRK_NEG_ODD`: the last pulse was negative and the count is odd.
- `TRK_POS_EVEN`: the last pulse was positive and the count is even.
- `TRK_POS_ODD`: the last pulse was positive and the count is odd.

It has two kinds of transition:
- **mark**: the state flips its polarity and its parity.
- **substitute**: an even state emits the pulse-led group, flips its polarity and returns to even. An odd state emits the zero-led group, keeps its polarity and returns to even.

Bits without an enable change nothing.

Top module: `zsub_line_encoder`

## Requirements
- R1: While `rst_n` is low, and after its release until output data arrives, `pos` and `neg` are both 0. After reset the tracker is in `TRK_NEG_EVEN`, so the first mark is emitted on `pos`.
- R2: Input 1 bits become marks whose polarity alternates from one mark to the next. Substitution pulses also count when deciding the polarity of the next mark.
- R3: The symbol for a bit captured at an enable appears on `pos`/`neg` after the fourth following enable, in both modes. The outputs change only in a cycle in which `bit_en` was high.
- R4: `pos` and `neg` are never high in the same cycle. `pos`=1 means a positive pulse and `neg`=1 means a negative pulse.
- R5: With `mode`=0 and `sub_en`=1, suppose three zeros complete while an odd number of pulses has been sent since the last violation. They are sent as 0,0,V, where V has the same polarity as the previous pulse.
- R6: With `mode`=0 and `sub_en`=1, suppose three zeros complete while that count is even. They are sent as B,0,V, where B has the polarity opposite to the previous pulse and V has the same polarity as B. Every violation sets the count back to even.
- R7: With `mode`=1 and `sub_en`=1, four zeros are sent as 0,0,0,V if the count is odd and as B,0,0,V if it is even. A run of only three zeros passes unchanged.
- R8: A zero run that spans several group lengths is split into back-to-back groups. Six zeros in `mode`=0 give two groups, and eight zeros in `mode`=1 give two groups.
- R9: With `sub_en`=0, zeros are sent as no pulse in either mode, whatever the run length.
- R10: The violation-parity count starts even at reset. A group completed before any mark is therefore of the B-led form, and its B and V are both positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Clock enable: one input bit and one output symbol per high cycle |
| din | input | 1 | Single-rail NRZ data bit |
| mode | input | 1 | 0 = three-zero substitution (DS3/STS-1), 1 = four-zero substitution (E3) |
| sub_en | input | 1 | 1 = zero substitution on, 0 = plain AMI |
| pos | output | 1 | Positive-pulse strobe for the current symbol |
| neg | output | 1 | Negative-pulse strobe for the current symbol |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that `bit_en`, `din`, `mode` and `sub_en` are stable around each rising edge. They do not assume that `mode` or `sub_en` stay fixed across a run. The bench changes its inputs only on falling edges and holds `mode` and `sub_en` constant from one reset to the next. This keeps every vector inside those assumptions and makes its expected symbol sequence fixed in advance.

// File: rtl/zsub_pkg.sv
package zsub_pkg;

    localparam int ZS_PIPE_DEPTH = 4;
    localparam int ZS_SHORT_RUN  = 3;
    localparam int ZS_LONG_RUN   = 4;

    // One line symbol: at most one rail set.
    typedef struct packed {
        logic p;
        logic n;
    } sym_t;

    localparam sym_t SYM_ZERO = '{p: 1'b0, n: 1'b0};
    localparam sym_t SYM_POS  = '{p: 1'b1, n: 1'b0};
    localparam sym_t SYM_NEG  = '{p: 1'b0, n: 1'b1};

    // Last pulse polarity combined with parity of pulses since last violation.
    typedef enum logic [1:0] {
        TRK_NEG_EVEN = 2'b00,
        TRK_NEG_ODD  = 2'b01,
        TRK_POS_EVEN = 2'b10,
        TRK_POS_ODD  = 2'b11
    } trk_state_t;

endpackage

// File: rtl/zsub_run_detect.sv
module zsub_run_detect
    import zsub_pkg::*;
#(
    parameter int SHORT_RUN  = ZS_SHORT_RUN,
    parameter int LONG_RUN   = ZS_LONG_RUN,
    parameter int PIPE_DEPTH = ZS_PIPE_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    input  logic                          din,
    input  logic                          mode,
    input  logic                          sub_en,
    output logic                          sub_hit,
    output logic [$clog2(PIPE_DEPTH)-1:0] b_idx
);

    localparam int RUN_W = (LONG_RUN > 2) ? $clog2(LONG_RUN) : 1;
    localparam int IDX_W = $clog2(PIPE_DEPTH);
    localparam logic [RUN_W-1:0] SHORT_THR = RUN_W'(SHORT_RUN - 1);
    localparam logic [RUN_W-1:0] LONG_THR  = RUN_W'(LONG_RUN - 1);
    localparam logic [IDX_W-1:0] SHORT_IDX = IDX_W'(SHORT_RUN - 1);
    localparam logic [IDX_W-1:0] LONG_IDX  = IDX_W'(LONG_RUN - 1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] thr;

    // Zeros already waiting in the pipeline, one fewer than a group.
    always_comb begin
        thr     = mode ? LONG_THR : SHORT_THR;
        b_idx   = mode ? LONG_IDX : SHORT_IDX;
        sub_hit = bit_en && sub_en && !din && (run_q >= thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_en) begin
            if (din || !sub_en || sub_hit) begin
                run_q <= '0;
            end else if (run_q < LONG_THR) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/zsub_pol_track.sv
module zsub_pol_track
    import zsub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic din,
    input  logic sub_hit,
    output sym_t ins_sym,
    output sym_t b_sym,
    output logic trk_even
);

    trk_state_t state_q;
    trk_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_NEG_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: mark or substitute; idle and plain zeros hold.
    always_comb begin
        state_d = state_q;
        if (bit_en) begin
            unique case (state_q)
                TRK_NEG_EVEN: begin
                    if (sub_hit)  state_d = TRK_POS_EVEN;
                    else if (din) state_d = TRK_POS_ODD;
                end
                TRK_NEG_ODD: begin
                    if (sub_hit)  state_d = TRK_NEG_EVEN;
                    else if (din) state_d = TRK_POS_EVEN;
                end
                TRK_POS_EVEN: begin
                    if (sub_hit)  state_d = TRK_NEG_EVEN;
                    else if (din) state_d = TRK_NEG_ODD;
                end
                TRK_POS_ODD: begin
                    if (sub_hit)  state_d = TRK_POS_EVEN;
                    else if (din) state_d = TRK_NEG_EVEN;
                end
            endcase
        end
    end

    // Outputs: symbol for the incoming slot and for the rewritten slot.
    always_comb begin
        sym_t mark_sym;
        sym_t viol_sym;
        sym_t lead_sym;
        mark_sym = SYM_ZERO;
        viol_sym = SYM_ZERO;
        lead_sym = SYM_ZERO;
        trk_even = 1'b0;
        unique case (state_q)
            TRK_NEG_EVEN: begin
                mark_sym = SYM_POS;
                lead_sym = SYM_POS;
                viol_sym = SYM_POS;
                trk_even = 1'b1;
            end
            TRK_NEG_ODD: begin
                mark_sym = SYM_POS;
                viol_sym = SYM_NEG;
            end
            TRK_POS_EVEN: begin
                mark_sym = SYM_NEG;
                lead_sym = SYM_NEG;
                viol_sym = SYM_NEG;
                trk_even = 1'b1;
            end
            TRK_POS_ODD: begin
                mark_sym = SYM_NEG;
                viol_sym = SYM_POS;
            end
        endcase
        if (sub_hit) begin
            ins_sym = viol_sym;
            b_sym   = lead_sym;
        end else begin
            ins_sym = din ? mark_sym : SYM_ZERO;
            b_sym   = SYM_ZERO;
        end
    end

endmodule

// File: rtl/zsub_sym_pipe.sv
module zsub_sym_pipe
    import zsub_pkg::*;
#(
    parameter int PIPE_DEPTH = ZS_PIPE_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    input  sym_t                          ins_sym,
    input  logic                          b_wr,
    input  logic [$clog2(PIPE_DEPTH)-1:0] b_idx,
    input  sym_t                          b_sym,
    output logic                          pos,
    output logic                          neg
);

    localparam int IDX_W = $clog2(PIPE_DEPTH);

    sym_t slot_q [PIPE_DEPTH];

    generate
        for (genvar i = 0; i < PIPE_DEPTH; i++) begin : g_slot
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        slot_q[i] <= SYM_ZERO;
                    end else if (bit_en) begin
                        slot_q[i] <= ins_sym;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        slot_q[i] <= SYM_ZERO;
                    end else if (bit_en) begin
                        if (b_wr && (b_idx == IDX_W'(i))) begin
                            slot_q[i] <= b_sym;
                        end else begin
                            slot_q[i] <= slot_q[i-1];
                        end
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= 1'b0;
            neg <= 1'b0;
        end else if (bit_en) begin
            pos <= slot_q[PIPE_DEPTH-1].p;
            neg <= slot_q[PIPE_DEPTH-1].n;
        end
    end

endmodule

// File: rtl/zsub_line_encoder.sv
module zsub_line_encoder
    import zsub_pkg::*;
#(
    parameter int SHORT_RUN  = ZS_SHORT_RUN,
    parameter int LONG_RUN   = ZS_LONG_RUN,
    parameter int PIPE_DEPTH = ZS_PIPE_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic din,
    input  logic mode,
    input  logic sub_en,
    output logic pos,
    output logic neg
);

    localparam int IDX_W = $clog2(PIPE_DEPTH);

    logic             sub_hit;
    logic [IDX_W-1:0] b_idx;
    logic             trk_even;
    sym_t             ins_sym;
    sym_t             b_sym;

    zsub_run_detect #(
        .SHORT_RUN (SHORT_RUN),
        .LONG_RUN  (LONG_RUN),
        .PIPE_DEPTH(PIPE_DEPTH)
    ) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .din    (din),
        .mode   (mode),
        .sub_en (sub_en),
        .sub_hit(sub_hit),
        .b_idx  (b_idx)
    );

    zsub_pol_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .din     (din),
        .sub_hit (sub_hit),
        .ins_sym (ins_sym),
        .b_sym   (b_sym),
        .trk_even(trk_even)
    );

    zsub_sym_pipe #(
        .PIPE_DEPTH(PIPE_DEPTH)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .ins_sym(ins_sym),
        .b_wr   (sub_hit),
        .b_idx  (b_idx),
        .b_sym  (b_sym),
        .pos    (pos),
        .neg    (neg)
    );

endmodule

// File: rtl/zsub_line_encoder_chk.sv
module zsub_line_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic sub_en,
    input logic pos,
    input logic neg,
    input logic sub_hit,
    input logic trk_even
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!pos && !neg)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(pos) && $stable(neg))); // R3

    AST_ONE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos && neg)); // R4

    AST_VIOL_CLEARS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        sub_hit |=> trk_even); // R6

    AST_AMI_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_en |-> !sub_hit); // R9

endmodule

bind zsub_line_encoder zsub_line_encoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .sub_en  (sub_en),
    .pos     (pos),
    .neg     (neg),
    .sub_hit (sub_hit),
    .trk_even(trk_even)
);

// File: tb/zsub_line_encoder_test.sv
module zsub_line_encoder_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n  = 1'b0;
    logic bit_en = 1'b0;
    logic din    = 1'b0;
    logic mode   = 1'b0;
    logic sub_en = 1'b0;
    logic pos;
    logic neg;

    int checks   = 0;
    int failures = 0;
    int both_cnt = 0;
    bit done     = 1'b0;

    zsub_line_encoder uut (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_en(bit_en),
        .din   (din),
        .mode  (mode),
        .sub_en(sub_en),
        .pos   (pos),
        .neg   (neg)
    );

    // {mode, sub_en, bits[11:0], pos[11:0], neg[11:0]}; first bit sent is the MSB.
    localparam int NVEC = 7;
    localparam logic [37:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 12'b100011000101, 12'b100101000100, 12'b000010101001},
        {1'b0, 1'b1, 12'b000000100111, 12'b101000100010, 12'b000101000101},
        {1'b1, 1'b1, 12'b100010000111, 12'b100001001010, 12'b000010000101},
        {1'b1, 1'b1, 12'b100000000101, 12'b100010000100, 12'b000001001001},
        {1'b0, 1'b0, 12'b100000110001, 12'b100000010000, 12'b000000100001},
        {1'b1, 1'b0, 12'b111000000001, 12'b101000000000, 12'b010000000001},
        {1'b0, 1'b1, 12'b110000100011, 12'b101010000010, 12'b010000100101}
    };

    function automatic string vec_req(input int idx);
        case (idx)
            0: return "R1 R5 R6 R2";
            1: return "R10 R8";
            2: return "R7";
            3: return "R7 R8";
            4: return "R9";
            5: return "R9 R2";
            default: return "R6 R5";
        endcase
    endfunction

    always @(negedge clk) if (pos && neg) both_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bit_en = 1'b0;
        din    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {30'd0, pos, neg}, 32'd0);

        // Table of vectors
        for (int v = 0; v < NVEC; v++) begin
            logic [11:0] pact;
            logic [11:0] nact;
            pact = '0;
            nact = '0;
            do_reset();
            mode   = VEC[v][37];
            sub_en = VEC[v][36];
            for (int s = 0; s <= 16; s++) begin
                if (s > 0) @(negedge clk);
                if (s >= 5) begin
                    pact[11 - (s - 5)] = pos;
                    nact[11 - (s - 5)] = neg;
                end
                din    = (s < 12) ? VEC[v][24 + 11 - s] : 1'b1;
                bit_en = 1'b1;
            end
            @(negedge clk);
            bit_en = 1'b0;
            check($sformatf("vector %0d (%s) pos/neg", v, vec_req(v)),
                  {8'd0, pact, nact}, {8'd0, VEC[v][23:12], VEC[v][11:0]});
        end

        // R3: latency of four enables with idle gaps, then hold
        do_reset();
        sub_en = 1'b0;
        mode   = 1'b0;
        bit_en = 1'b1;
        din    = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            bit_en = 1'b1;
            din    = 1'b0;
            @(negedge clk);
            bit_en = 1'b0;
            @(negedge clk);
        end
        check("R3 no symbol before fourth following enable", {30'd0, pos, neg}, 32'd0);
        bit_en = 1'b1;
        din    = 1'b0;
        @(negedge clk);
        bit_en = 1'b0;
        check("R3 mark after fourth following enable", {30'd0, pos, neg}, 32'd2);
        repeat (3) @(negedge clk);
        check("R3 output held without enable", {30'd0, pos, neg}, 32'd2);

        // R4: both rails never seen together
        check("R4 both rails high count", both_cnt, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule